// File: doc/BRIEF.md
# Receiver Termination Detect Controller

This block decides, for each lane group of a multi-lane signal conditioner, when the receive-side common-mode termination leaves its high-impedance state and switches to the low-impedance load. It sends probe requests to an external far-end detector over a request/done handshake and counts the valid results. It enables a group's termination only after a run of consecutive valid probes whose length depends on a shared multi-level mode input. One mode level bypasses detection, so the load stays on whenever the group is not powered down.

Each lane group has its own power-down input. Group 0 stands for lanes 0 to 3 and group 1 for lanes 4 to 7. Each input passes through a two-flop synchronizer and a pulse-width qualifier. A qualified power-down forces that group's termination off, stops its probing and clears its detection state. Detection starts again when the input returns low. The groups run independently, so one can stay powered down while the other detects. The poll interval and the minimum power-down width are parameters counted in clock cycles.

Top module: `rxterm_detect_ctrl`

## Requirements
- R1: With `mode` = 0, `term_en` is 1 for every group whose power-down is not qualified, and `probe_req` stays 0.
- R2: With `mode` = 1, a group's `term_en` rises only at the clock edge that samples the third valid result of an unbroken run of valid probe results.
- R3: With `mode` = 2, a run of two consecutive valid results enables the termination.
- R4: With `mode` = 4, and also with 3, 5, 6 and 7, a single valid result enables the termination. Until then `term_en` stays 0.
- R5: A probe result with `probe_valid` = 0 resets the consecutive-valid run to zero, so the following probes must build a full run again.
- R6: After a result that does not complete the run, the next `probe_req` rises exactly POLL_CYCLES clock cycles after the edge that sampled `probe_done`.
- R7: After reset or after the end of a qualified power-down, the first probe of a group is issued without waiting for the poll interval.
- R8: A power-down pin held high for at least PD_MIN_CYCLES cycles forces that group's `term_en` and `probe_req` to 0 in every mode. Detection restarts from an empty run once the pin returns low.
- R9: A power-down pulse shorter than PD_MIN_CYCLES cycles has no effect: an enabled termination stays enabled.
- R10: The two groups are independent. A group held in power-down keeps `term_en` = 0 while the other group probes and enables.
- R11: `probe_req` stays high until `probe_done` is sampled. A `probe_done` that arrives while `probe_req` is low is ignored. Once a group's termination is enabled, that group issues no further probes.
- R12: During and right after reset, with a nonzero mode, all `term_en` and `probe_req` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Detection mode level (0 to 7) |
| pd_in | input | N_GRP | Per-group power-down pins, asynchronous |
| probe_req | output | N_GRP | Probe request to the far-end detector |
| probe_done | input | N_GRP | Detector has finished the current probe (one-cycle pulse) |
| probe_valid | input | N_GRP | Detector result; sampled only while `probe_done` is high |
| term_en | output | N_GRP | 1 = low-impedance termination enabled, 0 = high impedance |

## Verification
The bench targets runs of valid results broken by a single invalid one. A design that only counts total successes would enable too early after an invalid result. The bench measures the exact spacing between a result and the next request, which catches an off-by-one in the poll timer. It sends a power-down pulse a few cycles too short to qualify, which catches a qualifier that drops the termination on a glitch. It also sends `probe_done` pulses while no request is pending, which a design with a loose handshake would count as a valid result. Further directed phases cover the reserved mode level and one group held in power-down while the other enables, which catches an implementation that couples the groups.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_PROBE = 2'd1,
      ST_LOCK  = 2'd2
   } grp_state_t;

   function automatic logic mode_is_off(input logic [MODE_W-1:0] m);
      return (m == '0);
   endfunction

   function automatic logic [1:0] runs_needed(input logic [MODE_W-1:0] m);
      case (m)
         3'd1:    return 2'd3;
         3'd2:    return 2'd2;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/rtd_pd_qual.sv
module rtd_pd_qual #(
   parameter int PD_MIN_CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_pin,
   output logic pd_act
);
   localparam int CNT_W = $clog2(PD_MIN_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PD_MIN_CYCLES - 1);

   generate
      if (PD_MIN_CYCLES < 2) begin : g_bad_width
         $error("rtd_pd_qual: PD_MIN_CYCLES must be at least 2");
      end
   endgenerate

   logic             sync_a, sync_b;
   logic [CNT_W-1:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_a   <= 1'b0;
         sync_b   <= 1'b0;
         high_cnt <= '0;
         pd_act   <= 1'b0;
      end else begin
         sync_a <= pd_pin;
         sync_b <= sync_a;
         if (!sync_b) begin
            high_cnt <= '0;
         end else if (high_cnt != CNT_TOP) begin
            high_cnt <= high_cnt + 1'b1;
         end
         pd_act <= sync_b && (high_cnt == CNT_TOP);
      end
   end

   // R9: qualification only follows a synchronized level that has stayed high
   assert_qual_needs_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_act) |-> $past(sync_b));

   // R8: a released pin drops the qualified power-down on the next edge
   assert_release_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_act && !sync_b) |=> !pd_act);

endmodule

// File: rtl/rtd_group_fsm.sv
module rtd_group_fsm
   import rtd_pkg::*;
#(
   parameter int POLL_CYCLES = 15000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [MODE_W-1:0] mode,
   input  logic              done,
   input  logic              valid,
   output logic              req,
   output logic              term_en
);
   localparam int TW = $clog2(POLL_CYCLES + 1);
   localparam logic [TW-1:0] T_LOAD = TW'(POLL_CYCLES - 1);

   generate
      if (POLL_CYCLES < 1) begin : g_bad_poll
         $error("rtd_group_fsm: POLL_CYCLES must be at least 1");
      end
   endgenerate

   grp_state_t    state;
   logic [TW-1:0] timer;
   logic [1:0]    run;
   logic [1:0]    need;
   logic          run_full;

   assign need     = runs_needed(mode);
   assign run_full = ({1'b0, run} + 3'd1) >= {1'b0, need};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_WAIT;
         timer <= '0;
         run   <= '0;
      end else if (hold) begin
         state <= ST_WAIT;
         timer <= '0;
         run   <= '0;
      end else begin
         case (state)
            ST_WAIT: begin
               if (!mode_is_off(mode)) begin
                  if (timer == '0) state <= ST_PROBE;
                  else             timer <= timer - 1'b1;
               end
            end
            ST_PROBE: begin
               if (done) begin
                  if (valid && run_full) begin
                     state <= ST_LOCK;
                  end else begin
                     state <= ST_WAIT;
                     timer <= T_LOAD;
                     run   <= valid ? run + 1'b1 : 2'd0;
                  end
               end
            end
            ST_LOCK: state <= ST_LOCK;
            default: state <= ST_WAIT;
         endcase
      end
   end

   assign req     = (state == ST_PROBE);
   assign term_en = !hold && (mode_is_off(mode) || (state == ST_LOCK));

   // R2: the enabled state is entered only on a sampled valid result
   assert_lock_on_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_LOCK) |-> ($past(done) && $past(valid)));

   // R5: the run counter never reaches the qualification count unlocked
   assert_run_below_need_R5: assert property (@(posedge clk) disable iff (!rst_n || hold)
      (state != ST_LOCK) |-> (run < need));

   // R6: no request while the poll timer is still running
   assert_interval_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && timer != '0) |=> !req);

   // R1: the bypass mode issues no new probe
   assert_no_probe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_is_off(mode) && state != ST_PROBE) |=> !req);

   // R8: power-down empties the detection state
   assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (state == ST_WAIT && run == 2'd0 && !req));

   // R11: a pending request is kept until the detector answers
   assert_req_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !done && !hold) |=> req);

endmodule

// File: rtl/rxterm_detect_ctrl.sv
module rxterm_detect_ctrl
   import rtd_pkg::*;
#(
   parameter int N_GRP         = 2,
   parameter int POLL_CYCLES   = 15000,
   parameter int PD_MIN_CYCLES = 20000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode,
   input  logic [N_GRP-1:0] pd_in,
   output logic [N_GRP-1:0] probe_req,
   input  logic [N_GRP-1:0] probe_done,
   input  logic [N_GRP-1:0] probe_valid,
   output logic [N_GRP-1:0] term_en
);
   generate
      if (N_GRP < 1) begin : g_bad_groups
         $error("rxterm_detect_ctrl: N_GRP must be at least 1");
      end
   endgenerate

   logic [N_GRP-1:0] pd_q;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      rtd_pd_qual #(
         .PD_MIN_CYCLES(PD_MIN_CYCLES)
      ) u_qual (
         .clk    (clk),
         .rst_n  (rst_n),
         .pd_pin (pd_in[g]),
         .pd_act (pd_q[g])
      );

      rtd_group_fsm #(
         .POLL_CYCLES(POLL_CYCLES)
      ) u_fsm (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold    (pd_q[g]),
         .mode    (mode),
         .done    (probe_done[g]),
         .valid   (probe_valid[g]),
         .req     (probe_req[g]),
         .term_en (term_en[g])
      );

      // R8: a qualified power-down keeps the group's load off from the next edge
      assert_pd_forces_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (pd_q[g] && $past(pd_q[g])) |-> (!term_en[g] && !probe_req[g]));
   end

endmodule

// File: tb/rxterm_detect_ctrl_bench.sv
`timescale 1ns/1ps
module rxterm_detect_ctrl_bench;
   localparam int NG    = 2;
   localparam int POLL  = 16;
   localparam int PDMIN = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'd4;
   logic [NG-1:0] pd = '0;
   logic [NG-1:0] done = '0;
   logic [NG-1:0] valid = '0;
   logic [NG-1:0] req;
   logic [NG-1:0] term;

   rxterm_detect_ctrl #(
      .N_GRP(NG), .POLL_CYCLES(POLL), .PD_MIN_CYCLES(PDMIN)
   ) u_rxterm_detect_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .pd_in(pd),
      .probe_req(req), .probe_done(done), .probe_valid(valid), .term_en(term)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;
   bit          en[NG];
   logic [15:0] pat[NG];
   int          patn[NG];
   int          run[NG];
   int          last_done[NG];
   bit          locked[NG];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic int need_of(input logic [2:0] m);
      case (m)
         3'd1:    return 3;
         3'd2:    return 2;
         default: return 1;
      endcase
   endfunction

   function automatic string mode_tag(input logic [2:0] m);
      case (m)
         3'd1:    return "R2";
         3'd2:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic responder(input int g);
      bit prev_req = 1'b0;
      forever begin
         @(negedge clk);
         if (!en[g]) begin
            prev_req = 1'b0;
         end else begin
            if (locked[g]) chk(!req[g], "R11 no probe after enable", int'(req[g]), 0);
            if (req[g] && !prev_req && last_done[g] >= 0)
               chk(cyc - last_done[g] == POLL, "R6 poll spacing", cyc - last_done[g], POLL);
            prev_req = req[g];
            if (req[g] && !locked[g]) begin
               int lat = $urandom % 3;
               repeat (lat) @(negedge clk);
               if (en[g] && req[g]) begin
                  bit v;
                  if (patn[g] > 0) begin
                     v = pat[g][0];
                     pat[g] = pat[g] >> 1;
                     patn[g]--;
                  end else begin
                     v = (($urandom % 4) != 0);
                  end
                  done[g]  = 1'b1;
                  valid[g] = v;
                  @(negedge clk);
                  done[g]  = 1'b0;
                  valid[g] = 1'b0;
                  last_done[g] = cyc;
                  if (v) run[g]++;
                  else   run[g] = 0;
                  if (run[g] >= need_of(mode)) begin
                     chk(term[g] == 1'b1, mode_tag(mode), int'(term[g]), 1);
                     locked[g] = 1'b1;
                  end else begin
                     chk(term[g] == 1'b0, v ? mode_tag(mode) : "R5", int'(term[g]), 0);
                  end
                  prev_req = req[g];
               end
            end
         end
      end
   endtask

   task automatic model_clear(input int g);
      run[g] = 0;
      last_done[g] = -1;
      locked[g] = 1'b0;
      patn[g] = 0;
   endtask

   // Hold both groups in power-down, change mode, then release the groups in rel_mask.
   task automatic phase(input logic [2:0] m, input logic [NG-1:0] rel_mask);
      for (int g = 0; g < NG; g++) en[g] = 1'b0;
      @(negedge clk);
      pd = '1;
      repeat (PDMIN + 6) @(negedge clk);
      mode = m;
      @(negedge clk);
      for (int g = 0; g < NG; g++) begin
         chk(term[g] == 1'b0, "R8 term off in power-down", int'(term[g]), 0);
         chk(req[g] == 1'b0, "R8 no probe in power-down", int'(req[g]), 0);
         model_clear(g);
      end
      pd = ~rel_mask;
   endtask

   task automatic wait_lock(input int g, input string tag);
      int n = 0;
      while (!locked[g] && n < 4000) begin
         @(negedge clk);
         n++;
      end
      chk(locked[g] == 1'b1, tag, int'(locked[g]), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
   end

   initial begin
      for (int g = 0; g < NG; g++) begin
         en[g] = 1'b0;
         pat[g] = '0;
         model_clear(g);
      end
      fork
         responder(0);
         responder(1);
      join_none
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      for (int g = 0; g < NG; g++) begin
         chk(term[g] == 1'b0, "R12 reset term", int'(term[g]), 0);
         chk(req[g] == 1'b0, "R12 reset req", int'(req[g]), 0);
      end
      rst_n = 1'b1;
      for (int g = 0; g < NG; g++) en[g] = 1'b1;
      // R7: first probe issued right after reset, no poll wait
      repeat (3) @(negedge clk);
      chk(req[0] == 1'b1 || last_done[0] >= 0, "R7 first probe", int'(req[0]), 1);
      wait_lock(0, "R4 default mode lock g0");
      wait_lock(1, "R4 default mode lock g1");

      // R9: short power-down pulse is ignored
      pd[0] = 1'b1;
      repeat (PDMIN - 3) @(negedge clk);
      pd[0] = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(term[0] == 1'b1, "R9 short pulse ignored", int'(term[0]), 1);
      end

      // R2/R5: three in a row, broken once: V V I V V V
      phase(3'd1, '1);
      pat[0] = 16'b111011; patn[0] = 6;
      for (int g = 0; g < NG; g++) en[g] = 1'b1;
      wait_lock(0, "R2 lock g0");
      wait_lock(1, "R2 lock g1");

      // R3/R5: V I V V
      phase(3'd2, '1);
      pat[0] = 16'b1101; patn[0] = 4;
      for (int g = 0; g < NG; g++) en[g] = 1'b1;
      wait_lock(0, "R3 lock g0");
      wait_lock(1, "R3 lock g1");

      // R4: reserved level behaves like default polling: I V
      phase(3'd3, '1);
      pat[0] = 16'b10; patn[0] = 2;
      for (int g = 0; g < NG; g++) en[g] = 1'b1;
      wait_lock(0, "R4 reserved lock g0");
      wait_lock(1, "R4 reserved lock g1");

      // R1: bypass mode
      phase(3'd0, '1);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         chk(term == '1, "R1 bypass term on", int'(term), 3);
         chk(req == '0, "R1 bypass no probe", int'(req), 0);
      end

      // R10: group 0 held down, group 1 detects
      phase(3'd4, 2'b10);
      en[1] = 1'b1;
      for (int k = 0; k < 120; k++) begin
         @(negedge clk);
         chk(term[0] == 1'b0 && req[0] == 1'b0, "R10 held group quiet", int'({term[0], req[0]}), 0);
         if (locked[1]) break;
      end
      wait_lock(1, "R10 free group enables");
      chk(term[0] == 1'b0, "R10 held group term", int'(term[0]), 0);

      // R11/R6: stray done pulses while no request is pending
      phase(3'd4, 2'b01);
      begin
         int t_done;
         int n = 0;
         while (!req[0] && n < 100) begin
            @(negedge clk);
            n++;
         end
         chk(req[0] == 1'b1, "R7 probe after release", int'(req[0]), 1);
         done[0] = 1'b1; valid[0] = 1'b0;
         @(negedge clk);
         t_done = cyc;
         done[0] = 1'b0;
         chk(req[0] == 1'b0, "R11 req drops after done", int'(req[0]), 0);
         repeat (3) begin
            done[0] = 1'b1; valid[0] = 1'b1;
            @(negedge clk);
         end
         done[0] = 1'b0; valid[0] = 1'b0;
         chk(term[0] == 1'b0, "R11 stray done ignored", int'(term[0]), 0);
         n = 0;
         while (!req[0] && n < 100) begin
            @(negedge clk);
            n++;
         end
         chk(cyc - t_done == POLL, "R6 spacing after invalid", cyc - t_done, POLL);
         done[0] = 1'b1; valid[0] = 1'b1;
         @(negedge clk);
         done[0] = 1'b0; valid[0] = 1'b0;
         chk(term[0] == 1'b1, "R4 single valid enables", int'(term[0]), 1);
      end

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule